// File: doc/BRIEF.md
# DMA Channel Interrupt Event Generator

This block follows the progress of a single DMA channel and decides when the CPU should get an interrupt. It never touches memory. It grants element transfers to an external data mover through `xfer_go`. It counts the completions the mover reports on `xfer_done`. When a programmed milestone is reached, it raises a one-cycle pulse on `irq`.

The channel runs in one of two transfer modes:

- **Ring mode.** A position runs from 0 up to a buffer length and then wraps. The interrupt points are the full-buffer point and, if selected, the half-buffer point.
- **Framed mode.** An element countdown runs inside each frame, and a frame countdown runs across the whole block. The interrupt points are the end of the block and, if selected, every frame end.

Element transfers are paced by a 4-bit sync selector. The selector either lets the channel run freely or ties each transfer to a rising edge on one of fourteen request inputs. These inputs are twelve serial-port events, a timer event and an external interrupt line.

A configuration is captured when `arm` is pulsed, and the channel becomes active on the next cycle. A ring channel runs until reset or until it is armed again. A framed channel stops by itself once its block is complete.

Top module: `dma_irq_event_gen`

## Requirements
- R1: A synchronous reset holds `irq` and `xfer_go` low, and the channel stays idle until `arm` is pulsed, even when the sync code is 0.
- R2: With the interrupt-enable bit at 0, `irq` never rises, in either mode and at either granularity.
- R3: In ring mode with the fine bit at 0, `irq` pulses only after the transfer that brings the position to the buffer length, which is the Nth transfer of each wrap.
- R4: In ring mode with the fine bit at 1, `irq` also pulses after the transfer that brings the position to floor(length/2), provided that value is nonzero.
- R5: In ring mode the position wraps to zero after the full point, and the channel keeps granting transfers.
- R6: In framed mode with the fine bit at 0, `irq` pulses once, after transfer number length × (frames_m1 + 1).
- R7: In framed mode with the fine bit at 1, `irq` pulses after the last transfer of every frame. The final frame end, which is also the block end, gives a single pulse.
- R8: After block completion in framed mode, `xfer_go` stays low and `xfer_done` has no effect until the next `arm`.
- R9: Sync code 0 runs the channel freely: `xfer_go` is high in every cycle the channel is active.
- R10: Sync codes 1–12 select `serial_evt[code-1]`, 13 selects `timer_evt` and 14 selects `ext_evt`. Each rising edge of the selected input grants exactly one transfer. A held level grants nothing more, and the other inputs grant nothing.
- R11: Sync code 15 is reserved, and with it selected the channel never grants a transfer.
- R12: `irq` is a registered one-cycle pulse. It is high in the cycle after the accepted transfer that reached the milestone, and it is low in the following idle cycle.
- R13: `xfer_done` has no effect on progress while `xfer_go` is low.
- R14: Arming with an element length of 0 leaves the channel idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Capture configuration and start the channel |
| cfg_ring | input | 1 | 1 = ring (circular) mode, 0 = framed mode |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_fine | input | 1 | 1 = half/frame points as well as full/block points |
| cfg_sync | input | 4 | Sync source code |
| cfg_len | input | EW | Buffer length (ring) or elements per frame (framed) |
| cfg_frames_m1 | input | FW | Frames per block minus one (framed) |
| serial_evt | input | 12 | Serial-port receive/transmit request events |
| timer_evt | input | 1 | Timer request event |
| ext_evt | input | 1 | External interrupt line |
| xfer_done | input | 1 | Data mover finished one element |
| xfer_go | output | 1 | One element transfer is permitted |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume three things about the inputs:
- The mover reports `xfer_done` only as a completion of a granted transfer, and a completion without a grant is discarded rather than counted.
- Configuration inputs matter only in the `arm` cycle.
- Sync inputs are synchronous levels whose edges are seen by comparing against the previous cycle.

The stimulus respects these assumptions in the following ways:
- It changes configuration only together with `arm`.
- It holds each source pulse for a full cycle and then lowers it for a full cycle, so that every intended edge is seen once.
- It raises `xfer_done` for one cycle per transfer, except in the tests that deliberately present it with no grant.

// File: rtl/dirq_pkg.sv
package dirq_pkg;

    localparam int SYNC_W   = 4;
    localparam int N_SERIAL = 12;
    localparam int N_SRC    = 1 << SYNC_W;

    localparam logic [SYNC_W-1:0] SYNC_FREE  = 4'd0;
    localparam logic [SYNC_W-1:0] SYNC_TIMER = 4'd13;
    localparam logic [SYNC_W-1:0] SYNC_EXT   = 4'd14;
    localparam logic [SYNC_W-1:0] SYNC_RSVD  = 4'd15;

    typedef enum logic {
        XM_FRAMED = 1'b0,
        XM_RING   = 1'b1
    } xfer_mode_e;

    typedef enum logic {
        GRAN_COARSE = 1'b0,
        GRAN_FINE   = 1'b1
    } irq_gran_e;

    // Control fields captured at arm time
    typedef struct packed {
        xfer_mode_e              mode;
        logic                    irq_en;
        irq_gran_e               gran;
        logic [SYNC_W-1:0]       sync;
    } chan_ctl_t;

    // Milestones reached by the transfer accepted this cycle
    typedef struct packed {
        logic half;
        logic full;
        logic frame_end;
        logic block_end;
    } prog_evt_t;

    localparam chan_ctl_t CTL_RESET = '{mode: XM_FRAMED, irq_en: 1'b0,
                                       gran: GRAN_COARSE, sync: SYNC_FREE};

    function automatic logic any_evt(prog_evt_t e);
        return e.half | e.full | e.frame_end | e.block_end;
    endfunction

endpackage

// File: rtl/dirq_sync_gate.sv
module dirq_sync_gate
    import dirq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                arm,
    input  logic                active,
    input  logic [SYNC_W-1:0]   sync_sel,
    input  logic [N_SERIAL-1:0] serial_evt,
    input  logic                timer_evt,
    input  logic                ext_evt,
    input  logic                xfer_done,
    output logic                go,
    output logic                accept
);

    logic [N_SRC-1:0] src, src_q, rise;
    logic             sel_rise, free_run, grant_q;

    always_comb begin
        src = '0;
        for (int i = 0; i < N_SERIAL; i++) src[i+1] = serial_evt[i];
        src[int'(SYNC_TIMER)] = timer_evt;
        src[int'(SYNC_EXT)]   = ext_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) src_q <= '0;
        else     src_q <= src;
    end

    assign rise     = src & ~src_q;
    assign sel_rise = rise[sync_sel] && (sync_sel != SYNC_RSVD) && (sync_sel != SYNC_FREE);
    assign free_run = (sync_sel == SYNC_FREE);
    assign go       = active & (free_run | grant_q);
    assign accept   = go & xfer_done;

    always_ff @(posedge clk) begin
        if (rst || arm || !active) grant_q <= 1'b0;
        else if (sel_rise)         grant_q <= 1'b1;
        else if (accept)           grant_q <= 1'b0;
    end

    assert_rsvd_blocks_R11: assert property (@(posedge clk) disable iff (rst)
        (active && sync_sel == SYNC_RSVD) |-> !go);

    assert_one_per_edge_R10: assert property (@(posedge clk) disable iff (rst)
        (accept && !free_run && !sel_rise && !arm) |=> !go);

    assert_free_runs_R9: assert property (@(posedge clk) disable iff (rst)
        (active && free_run) |-> go);

endmodule

// File: rtl/dirq_progress.sv
module dirq_progress
    import dirq_pkg::*;
#(
    parameter int EW = 16,
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  xfer_mode_e    mode_in,
    input  xfer_mode_e    mode_q,
    input  logic [EW-1:0] len_in,
    input  logic [FW-1:0] frames_m1_in,
    input  logic          accept,
    output logic          active,
    output prog_evt_t     evt
);

    logic [EW-1:0] pos_q, len_q, nxt, half_pt;
    logic [FW-1:0] frm_q;
    logic          acc_eff;

    assign acc_eff = accept & ~arm;
    assign nxt     = pos_q + EW'(1);
    assign half_pt = len_q >> 1;

    always_comb begin
        evt = '0;
        if (mode_q == XM_RING) begin
            evt.full = acc_eff && (nxt == len_q);
            evt.half = acc_eff && (half_pt != '0) && (nxt == half_pt);
        end else begin
            evt.frame_end = acc_eff && (pos_q == EW'(1));
            evt.block_end = evt.frame_end && (frm_q == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            pos_q  <= '0;
            len_q  <= '0;
            frm_q  <= '0;
        end else if (arm) begin
            len_q  <= len_in;
            frm_q  <= frames_m1_in;
            active <= (len_in != '0);
            pos_q  <= (mode_in == XM_RING) ? '0 : len_in;
        end else if (acc_eff) begin
            if (mode_q == XM_RING) begin
                pos_q <= evt.full ? '0 : nxt;
            end else if (evt.frame_end) begin
                if (evt.block_end) begin
                    active <= 1'b0;
                    pos_q  <= '0;
                end else begin
                    frm_q <= frm_q - FW'(1);
                    pos_q <= len_q;
                end
            end else begin
                pos_q <= pos_q - EW'(1);
            end
        end
    end

    assert_ring_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (active && mode_q == XM_RING) |-> (pos_q < len_q));

    assert_idle_after_block_R8: assert property (@(posedge clk) disable iff (rst)
        (evt.block_end && !arm) |=> !active);

    assert_frame_reload_R7: assert property (@(posedge clk) disable iff (rst)
        (evt.frame_end && !evt.block_end && !arm) |=> (pos_q == len_q));

    assert_zero_len_idle_R14: assert property (@(posedge clk) disable iff (rst)
        (arm && len_in == '0) |=> !active);

endmodule

// File: rtl/dirq_irq_out.sv
module dirq_irq_out
    import dirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  xfer_mode_e mode,
    input  logic       irq_en,
    input  irq_gran_e  gran,
    input  prog_evt_t  evt,
    output logic       irq
);

    logic fine, fire;

    assign fine = (gran == GRAN_FINE);

    always_comb begin
        if (mode == XM_RING) fire = evt.full      | (fine & evt.half);
        else                 fire = evt.block_end | (fine & evt.frame_end);
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= irq_en & fire;
    end

    assert_irq_needs_en_R2: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(irq_en));

    assert_irq_has_cause_R12: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(any_evt(evt)));

    assert_coarse_ring_full_R3: assert property (@(posedge clk) disable iff (rst)
        (irq && $past(mode == XM_RING && gran == GRAN_COARSE)) |-> $past(evt.full));

    assert_coarse_framed_block_R6: assert property (@(posedge clk) disable iff (rst)
        (irq && $past(mode == XM_FRAMED && gran == GRAN_COARSE)) |-> $past(evt.block_end));

endmodule

// File: rtl/dma_irq_event_gen.sv
module dma_irq_event_gen
    import dirq_pkg::*;
#(
    parameter int EW = 16,
    parameter int FW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                arm,
    input  logic                cfg_ring,
    input  logic                cfg_irq_en,
    input  logic                cfg_fine,
    input  logic [SYNC_W-1:0]   cfg_sync,
    input  logic [EW-1:0]       cfg_len,
    input  logic [FW-1:0]       cfg_frames_m1,
    input  logic [N_SERIAL-1:0] serial_evt,
    input  logic                timer_evt,
    input  logic                ext_evt,
    input  logic                xfer_done,
    output logic                xfer_go,
    output logic                irq
);

    chan_ctl_t ctl_in, ctl_q;
    prog_evt_t evt;
    logic      active, accept;

    assign ctl_in = '{mode:   cfg_ring ? XM_RING : XM_FRAMED,
                      irq_en: cfg_irq_en,
                      gran:   cfg_fine ? GRAN_FINE : GRAN_COARSE,
                      sync:   cfg_sync};

    always_ff @(posedge clk) begin
        if (rst)      ctl_q <= CTL_RESET;
        else if (arm) ctl_q <= ctl_in;
    end

    dirq_sync_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .arm        (arm),
        .active     (active),
        .sync_sel   (ctl_q.sync),
        .serial_evt (serial_evt),
        .timer_evt  (timer_evt),
        .ext_evt    (ext_evt),
        .xfer_done  (xfer_done),
        .go         (xfer_go),
        .accept     (accept)
    );

    dirq_progress #(.EW(EW), .FW(FW)) u_prog (
        .clk          (clk),
        .rst          (rst),
        .arm          (arm),
        .mode_in      (ctl_in.mode),
        .mode_q       (ctl_q.mode),
        .len_in       (cfg_len),
        .frames_m1_in (cfg_frames_m1),
        .accept       (accept),
        .active       (active),
        .evt          (evt)
    );

    dirq_irq_out u_irq (
        .clk    (clk),
        .rst    (rst),
        .mode   (ctl_q.mode),
        .irq_en (ctl_q.irq_en),
        .gran   (ctl_q.gran),
        .evt    (evt),
        .irq    (irq)
    );

    assert_idle_no_go_R8: assert property (@(posedge clk) disable iff (rst)
        !active |-> !xfer_go);

endmodule

// File: tb/dma_irq_event_gen_bench.sv
module dma_irq_event_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int EW = 16;
    localparam int FW = 8;

    // entry = {expect_go_after_edge, expect_irq, sync_code}
    localparam logic [5:0] SYNC_VEC [16] = '{
        {2'b11, 4'd0},  {2'b11, 4'd1},  {2'b11, 4'd2},  {2'b11, 4'd3},
        {2'b11, 4'd4},  {2'b11, 4'd5},  {2'b11, 4'd6},  {2'b11, 4'd7},
        {2'b11, 4'd8},  {2'b11, 4'd9},  {2'b11, 4'd10}, {2'b11, 4'd11},
        {2'b11, 4'd12}, {2'b11, 4'd13}, {2'b11, 4'd14}, {2'b00, 4'd15}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          arm = 1'b0;
    logic          cfg_ring = 1'b0, cfg_irq_en = 1'b0, cfg_fine = 1'b0;
    logic [3:0]    cfg_sync = '0;
    logic [EW-1:0] cfg_len = '0;
    logic [FW-1:0] cfg_frames_m1 = '0;
    logic [11:0]   serial_evt = '0;
    logic          timer_evt = 1'b0, ext_evt = 1'b0, xfer_done = 1'b0;
    logic          xfer_go, irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_irq_event_gen #(.EW(EW), .FW(FW)) u_dma_irq_event_gen (
        .clk(clk), .rst(rst), .arm(arm), .cfg_ring(cfg_ring), .cfg_irq_en(cfg_irq_en),
        .cfg_fine(cfg_fine), .cfg_sync(cfg_sync), .cfg_len(cfg_len),
        .cfg_frames_m1(cfg_frames_m1), .serial_evt(serial_evt), .timer_evt(timer_evt),
        .ext_evt(ext_evt), .xfer_done(xfer_done), .xfer_go(xfer_go), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic arm_ch(input bit ring, input bit en, input bit fine,
                          input int sync, input int len, input int fm1);
        cfg_ring = ring; cfg_irq_en = en; cfg_fine = fine;
        cfg_sync = 4'(sync); cfg_len = EW'(len); cfg_frames_m1 = FW'(fm1);
        arm = 1'b1;
        step();
        arm = 1'b0;
    endtask

    task automatic set_src(input int idx, input logic v);
        if (idx >= 1 && idx <= 12) serial_evt[idx-1] = v;
        else if (idx == 13)        timer_evt = v;
        else if (idx == 14)        ext_evt = v;
    endtask

    task automatic pulse_src(input int idx);
        set_src(idx, 1'b1);
        step();
        set_src(idx, 1'b0);
        step();
    endtask

    task automatic pulse_others(input int code);
        for (int i = 1; i <= 14; i++) if (i != code) set_src(i, 1'b1);
        step();
        for (int i = 1; i <= 14; i++) set_src(i, 1'b0);
        step();
    endtask

    task automatic xfer(output logic irq_seen);
        xfer_done = 1'b1;
        step();
        xfer_done = 1'b0;
        irq_seen = irq;
    endtask

    function automatic bit exp_irq(bit ring, bit en, bit fine, int len, int fm1, int k);
        int total;
        if (!en) return 1'b0;
        if (ring) return (k % len == 0) || (fine && (len / 2 > 0) && (k % len == len / 2));
        total = len * (fm1 + 1);
        if (k > total)  return 1'b0;
        if (k == total) return 1'b1;
        return fine && (k % len == 0);
    endfunction

    task automatic run_free(input string req, input bit ring, input bit en, input bit fine,
                            input int len, input int fm1, input int n);
        logic seen;
        arm_ch(ring, en, fine, 0, len, fm1);
        for (int k = 1; k <= n; k++) begin
            check({req, " R9 go while active"}, int'(xfer_go), 1);
            xfer(seen);
            check({req, " irq pattern"}, int'(seen), int'(exp_irq(ring, en, fine, len, fm1, k)));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic seen;
        logic [5:0] v;
        int code;

        // R1: reset state
        step(); step();
        check("R1 irq in reset", int'(irq), 0);
        check("R1 go in reset", int'(xfer_go), 0);
        rst = 1'b0;
        step();
        cfg_sync = 4'd0; cfg_len = EW'(4);
        step();
        check("R1 go idle before arm", int'(xfer_go), 0);
        check("R1 irq idle before arm", int'(irq), 0);

        // R10 R11: sync source table, ring len 1 coarse
        for (int i = 0; i < 16; i++) begin
            v = SYNC_VEC[i];
            code = int'(v[3:0]);
            arm_ch(1'b1, 1'b1, 1'b0, code, 1, 0);
            if (code != 0) begin
                check("R10 no grant before edge", int'(xfer_go), 0);
                pulse_others(code);
                check("R10 other sources grant nothing", int'(xfer_go), 0);
                if (code <= 14) pulse_src(code);
            end
            check((code == 15) ? "R11 reserved never grants" : "R10 selected edge grants",
                  int'(xfer_go), int'(v[5]));
            xfer(seen);
            check((code == 15) ? "R11 reserved no irq" : "R10 transfer irq",
                  int'(seen), int'(v[4]));
            check("R10 one transfer per edge", int'(xfer_go), (code == 0) ? 1 : 0);
        end

        // R3 R5: ring coarse
        run_free("R3", 1'b1, 1'b1, 1'b0, 4, 0, 8);
        check("R5 keeps running after wrap", int'(xfer_go), 1);
        // R12: pulse is one cycle wide
        step();
        check("R12 irq low in idle cycle", int'(irq), 0);

        // R4: ring fine, odd length (half point 2)
        run_free("R4", 1'b1, 1'b1, 1'b1, 5, 0, 10);
        // R4: length 1 has no half point
        run_free("R4 len1", 1'b1, 1'b1, 1'b1, 1, 0, 3);

        // R2: interrupts disabled
        run_free("R2 ring", 1'b1, 1'b0, 1'b1, 4, 0, 8);
        run_free("R2 framed", 1'b0, 1'b0, 1'b1, 3, 1, 6);

        // R6 R8: framed coarse
        run_free("R6", 1'b0, 1'b1, 1'b0, 3, 2, 9);
        check("R8 idle after block", int'(xfer_go), 0);
        xfer(seen);
        check("R8 done after block ignored", int'(seen), 0);
        check("R8 still idle", int'(xfer_go), 0);

        // R7: framed fine, final frame end coincides with block end
        run_free("R7", 1'b0, 1'b1, 1'b1, 2, 2, 6);
        check("R7 idle after block", int'(xfer_go), 0);
        step();
        check("R12 single pulse at coincident end", int'(irq), 0);

        // R13: done without grant does not advance (ring len 2, timer sync)
        arm_ch(1'b1, 1'b1, 1'b0, 13, 2, 0);
        xfer(seen);
        check("R13 ungranted done no irq", int'(seen), 0);
        xfer(seen);
        check("R13 ungranted done no irq again", int'(seen), 0);
        pulse_src(13);
        xfer(seen);
        check("R13 first granted transfer is position 1", int'(seen), 0);
        pulse_src(13);
        xfer(seen);
        check("R13 second granted transfer fills buffer", int'(seen), 1);

        // R10: held level grants once
        arm_ch(1'b1, 1'b1, 1'b0, 14, 4, 0);
        ext_evt = 1'b1;
        step();
        check("R10 rising level grants", int'(xfer_go), 1);
        xfer(seen);
        check("R10 held level no regrant", int'(xfer_go), 0);
        step(); step();
        check("R10 held level still no grant", int'(xfer_go), 0);
        ext_evt = 1'b0;
        step();

        // R14: zero length
        arm_ch(1'b1, 1'b1, 1'b0, 0, 0, 0);
        check("R14 ring zero length idle", int'(xfer_go), 0);
        arm_ch(1'b0, 1'b1, 1'b0, 0, 0, 3);
        check("R14 framed zero length idle", int'(xfer_go), 0);

        // R1: reset mid-run
        arm_ch(1'b1, 1'b1, 1'b0, 0, 1, 0);
        xfer_done = 1'b1;
        rst = 1'b1;
        step();
        xfer_done = 1'b0;
        check("R1 reset clears irq", int'(irq), 0);
        rst = 1'b0;
        step();
        check("R1 reset disables channel", int'(xfer_go), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule